// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block walks the element and sub-element index space of one vector operation. Once a start pulse latches the element count, sub-vector size, ordering flags, mode flag and hint, it emits a tuple of four indices: source element, source sub-element, destination element and destination sub-element. A valid strobe marks each issued tuple. The source and the destination each have their own nesting order. By default the sub-element index turns fastest. Either side can be switched, on its own, so that its element index turns fastest.

In horizontal mode the block issues one tuple per clock until the whole space is covered, then raises done. In vertical-first mode the indices stay put until a step request arrives. A step request then issues a short burst. With a nonzero hint the burst covers the rest of the current independence group and halts after that group's last tuple. With a zero hint the burst is exactly one tuple. A group-end flag marks the tuple after which the group number of the source element changes. The group number is the source element index divided by the hint, rounded down. The flag is also raised on the final tuple.

Top module: `vec_step_seq`

## Requirements
- R1: While reset is low, and after reset until the first start, valid_o and done_o are 0 and all four index outputs are 0.
- R2: In horizontal mode with no inversion, the first tuple is valid in the cycle after start, and one tuple is issued per cycle after that. The sub-element index is the inner loop and the element index is the outer loop. Exactly VL*SUBVL tuples are issued. SUBVL is subvl_i+1.
- R3: With pack_i set at start, the source side runs with the element index inner and the sub-element index outer. The destination side is not affected.
- R4: With unpack_i set at start, the destination side is inverted in the same way. This is independent of pack_i.
- R5: done_o rises in the cycle after the final tuple and stays high until the next start. valid_o is never high while done_o is high.
- R6: A start with vl_i equal to 0 raises done_o in the next cycle, and no tuple is issued.
- R7: In vertical-first mode (vfirst_i set at start), the indices hold and valid_o stays low until step_i is sampled high. step_i has no effect while a burst is issuing, in horizontal mode, or after done.
- R8: In vertical-first mode with a nonzero hint, a step request issues consecutive tuples from the next cycle on. The burst ends after the tuple flagged group-end, and the block then waits for the next step request.
- R9: In vertical-first mode with hint 0, each step request issues exactly one tuple.
- R10: grp_end_o is high on a valid tuple when it is the final tuple. It is also high when the hint is nonzero and floor(src/hint) of the next tuple differs from that of the current tuple. With hint 0, only the final tuple is flagged.
- R11: A start during a run abandons the run. The new operation begins in the next cycle from index 0, using the newly latched settings.
- R12: The configuration inputs are sampled only on the start cycle. Changes to them afterwards do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Latch the configuration and begin a new sequence |
| step_i | input | 1 | Step request used in vertical-first mode |
| vl_i | input | 7 | Element count VL, from 0 to 127 |
| subvl_i | input | 2 | Sub-vector size minus one |
| pack_i | input | 1 | Invert the source nesting order |
| unpack_i | input | 1 | Invert the destination nesting order |
| vfirst_i | input | 1 | Vertical-first mode select |
| hphint_i | input | 7 | Group size hint, 0 for none |
| src_idx_o | output | 7 | Source element index |
| src_sub_o | output | 2 | Source sub-element index |
| dst_idx_o | output | 7 | Destination element index |
| dst_sub_o | output | 2 | Destination sub-element index |
| valid_o | output | 1 | The current tuple is issued this cycle |
| grp_end_o | output | 1 | The current tuple closes its group or the sequence |
| done_o | output | 1 | The sequence is complete |

## Verification
The bench targets mixed orderings, where only one side is inverted. A design that shared a single counter between the two sides would show the destination following the source order. In pack order the source element wraps back to 0 partway through the sequence. Here a group boundary exists only if the element had left group 0, and a design that always or never flagged the wrap shows up at once. The bench also runs hints larger than VL, a VL of 0 and a VL of 1, and a start issued mid-run. A stale latched configuration would show up in those cases, and so would an off-by-one in done timing. Vertical-first runs mix in step pulses while a burst is issuing. A design that let such pulses advance the indices would drift from the reference tuple order.

// File: rtl/vss_pkg.sv
// Package: shared state encoding and default widths for the step sequencer.
// Assumes: nothing beyond plain SystemVerilog.
package vss_pkg;

    // Default widths: element index, sub-element index, hint value.
    localparam int unsigned VSS_STEP_W = 7;
    localparam int unsigned VSS_SUB_W  = 2;
    localparam int unsigned VSS_HINT_W = 7;

    // Sequencer control states.
    typedef enum logic [1:0] {
        VSS_IDLE  = 2'd0,
        VSS_RUN   = 2'd1,
        VSS_PAUSE = 2'd2,
        VSS_DONE  = 2'd3
    } vss_state_e;

endpackage

// File: rtl/vss_nest_cnt.sv
// Module: two-level nested index counter (element x sub-element).
// Normal order turns the sub-element index fastest; invert_i makes the
// element index the inner loop. Assumes elem_max_i/sub_max_i are stable
// while advance_i may be asserted.
module vss_nest_cnt #(
    parameter int unsigned EW = 7,
    parameter int unsigned SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          advance_i,
    input  logic          invert_i,
    input  logic [EW-1:0] elem_max_i,
    input  logic [SW-1:0] sub_max_i,
    output logic [EW-1:0] elem_o,
    output logic [SW-1:0] sub_o
);

    logic [EW-1:0] elem_q, elem_d;
    logic [SW-1:0] sub_q, sub_d;
    logic          elem_end, sub_end;

    assign elem_end = (elem_q == elem_max_i);
    assign sub_end  = (sub_q == sub_max_i);

    // Next-index computation for either nesting order.
    always_comb begin
        elem_d = elem_q;
        sub_d  = sub_q;
        if (invert_i) begin
            if (elem_end) begin
                elem_d = '0;
                sub_d  = sub_end ? '0 : sub_q + 1'b1;
            end else begin
                elem_d = elem_q + 1'b1;
            end
        end else begin
            if (sub_end) begin
                sub_d  = '0;
                elem_d = elem_end ? '0 : elem_q + 1'b1;
            end else begin
                sub_d = sub_q + 1'b1;
            end
        end
    end

    // Index registers: cleared on reset or start, stepped on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            elem_q <= '0;
            sub_q  <= '0;
        end else if (advance_i) begin
            elem_q <= elem_d;
            sub_q  <= sub_d;
        end
    end

    assign elem_o = elem_q;
    assign sub_o  = sub_q;

endmodule

// File: rtl/vss_hint_grp.sv
// Module: tracks the position of the source element within its hint group
// and flags the tuple after which the group number changes (or the final
// tuple). Avoids a divider by counting element moves incrementally.
// Assumes it sees the same advance/clear and order as the source counter.
module vss_hint_grp #(
    parameter int unsigned EW = 7,
    parameter int unsigned SW = 2,
    parameter int unsigned HW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          advance_i,
    input  logic          invert_i,
    input  logic [EW-1:0] elem_i,
    input  logic [SW-1:0] sub_i,
    input  logic [EW-1:0] elem_max_i,
    input  logic [SW-1:0] sub_max_i,
    input  logic [HW-1:0] hint_i,
    input  logic          last_i,
    output logic          grp_end_o
);

    logic [HW-1:0] pos_q;
    logic [EW-1:0] gidx_q;
    logic [HW-1:0] hint_m1;
    logic          hint_on, pos_top;
    logic          elem_inc, elem_wrap;

    assign hint_on = (hint_i != '0);
    assign hint_m1 = hint_i - HW'(1);
    assign pos_top = (pos_q == hint_m1);

    // How the source element moves on the next advance.
    always_comb begin
        if (invert_i) begin
            elem_inc  = (elem_i != elem_max_i);
            elem_wrap = (elem_i == elem_max_i);
        end else begin
            elem_inc  = (sub_i == sub_max_i) && (elem_i != elem_max_i);
            elem_wrap = (sub_i == sub_max_i) && (elem_i == elem_max_i);
        end
    end

    // Group boundary: crossing a multiple of the hint, or wrapping to 0 from a later group.
    assign grp_end_o = last_i ||
                       (hint_on && ((elem_inc && pos_top) ||
                                    (elem_wrap && (gidx_q != '0))));

    // Position-in-group and group-number registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pos_q  <= '0;
            gidx_q <= '0;
        end else if (advance_i) begin
            if (elem_wrap) begin
                pos_q  <= '0;
                gidx_q <= '0;
            end else if (elem_inc) begin
                if (hint_on && pos_top) begin
                    pos_q  <= '0;
                    gidx_q <= gidx_q + 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vss_ctrl.sv
// Module: run/pause/done control for the step sequencer.
// Horizontal mode runs continuously; vertical-first mode pauses after
// each burst and resumes on a step request. Assumes last_i and grp_end_i
// describe the tuple currently presented.
module vss_ctrl
    import vss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    input  logic new_vl_zero_i,
    input  logic new_vfirst_i,
    input  logic cfg_vfirst_i,
    input  logic cfg_hint_zero_i,
    input  logic grp_end_i,
    input  logic last_i,
    output logic valid_o,
    output logic done_o,
    output logic advance_o
);

    vss_state_e state_q, state_d;

    // Next-state selection; a start overrides everything.
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            if (new_vl_zero_i)     state_d = VSS_DONE;
            else if (new_vfirst_i) state_d = VSS_PAUSE;
            else                   state_d = VSS_RUN;
        end else begin
            unique case (state_q)
                VSS_RUN: begin
                    if (last_i)
                        state_d = VSS_DONE;
                    else if (cfg_vfirst_i && (cfg_hint_zero_i || grp_end_i))
                        state_d = VSS_PAUSE;
                end
                VSS_PAUSE: if (step_i) state_d = VSS_RUN;
                default:   state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VSS_IDLE;
        else        state_q <= state_d;
    end

    assign valid_o   = (state_q == VSS_RUN);
    assign done_o    = (state_q == VSS_DONE);
    assign advance_o = (state_q == VSS_RUN) && !last_i && !start_i;

endmodule

// File: rtl/vec_step_seq.sv
// Module: vector element step sequencer top.
// Latches the configuration on start, drives independent source and
// destination nested counters, the hint-group tracker and the control FSM.
// Assumes subvl_i encodes the sub-vector size minus one.
module vec_step_seq
    import vss_pkg::*;
#(
    parameter int unsigned STEP_W = VSS_STEP_W,
    parameter int unsigned SUB_W  = VSS_SUB_W,
    parameter int unsigned HINT_W = VSS_HINT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic [SUB_W-1:0]  subvl_i,
    input  logic              pack_i,
    input  logic              unpack_i,
    input  logic              vfirst_i,
    input  logic [HINT_W-1:0] hphint_i,
    output logic [STEP_W-1:0] src_idx_o,
    output logic [SUB_W-1:0]  src_sub_o,
    output logic [STEP_W-1:0] dst_idx_o,
    output logic [SUB_W-1:0]  dst_sub_o,
    output logic              valid_o,
    output logic              grp_end_o,
    output logic              done_o
);

    logic [STEP_W-1:0] cfg_vl_m1;
    logic [SUB_W-1:0]  cfg_sub_m1;
    logic              cfg_pack, cfg_unpack, cfg_vfirst;
    logic [HINT_W-1:0] cfg_hint;
    logic              advance, is_last;

    // Configuration capture on start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_vl_m1  <= '0;
            cfg_sub_m1 <= '0;
            cfg_pack   <= 1'b0;
            cfg_unpack <= 1'b0;
            cfg_vfirst <= 1'b0;
            cfg_hint   <= '0;
        end else if (start_i) begin
            cfg_vl_m1  <= vl_i - STEP_W'(1);
            cfg_sub_m1 <= subvl_i;
            cfg_pack   <= pack_i;
            cfg_unpack <= unpack_i;
            cfg_vfirst <= vfirst_i;
            cfg_hint   <= hphint_i;
        end
    end

    // The final tuple is the same position in both nesting orders.
    assign is_last = (src_idx_o == cfg_vl_m1) && (src_sub_o == cfg_sub_m1);

    vss_nest_cnt #(.EW(STEP_W), .SW(SUB_W)) src_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .advance_i  (advance),
        .invert_i   (cfg_pack),
        .elem_max_i (cfg_vl_m1),
        .sub_max_i  (cfg_sub_m1),
        .elem_o     (src_idx_o),
        .sub_o      (src_sub_o)
    );

    vss_nest_cnt #(.EW(STEP_W), .SW(SUB_W)) dst_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .advance_i  (advance),
        .invert_i   (cfg_unpack),
        .elem_max_i (cfg_vl_m1),
        .sub_max_i  (cfg_sub_m1),
        .elem_o     (dst_idx_o),
        .sub_o      (dst_sub_o)
    );

    vss_hint_grp #(.EW(STEP_W), .SW(SUB_W), .HW(HINT_W)) grp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .advance_i  (advance),
        .invert_i   (cfg_pack),
        .elem_i     (src_idx_o),
        .sub_i      (src_sub_o),
        .elem_max_i (cfg_vl_m1),
        .sub_max_i  (cfg_sub_m1),
        .hint_i     (cfg_hint),
        .last_i     (is_last),
        .grp_end_o  (grp_end_o)
    );

    vss_ctrl ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .step_i          (step_i),
        .new_vl_zero_i   (vl_i == '0),
        .new_vfirst_i    (vfirst_i),
        .cfg_vfirst_i    (cfg_vfirst),
        .cfg_hint_zero_i (cfg_hint == '0),
        .grp_end_i       (grp_end_o),
        .last_i          (is_last),
        .valid_o         (valid_o),
        .done_o          (done_o),
        .advance_o       (advance)
    );

endmodule

// File: rtl/vss_chk.sv
// Module: property checker for the step sequencer, attached by bind.
// Observes ports only.
module vss_chk #(
    parameter int unsigned EW = 7,
    parameter int unsigned SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          step_i,
    input logic [EW-1:0] vl_i,
    input logic [EW-1:0] src_idx_o,
    input logic [SW-1:0] src_sub_o,
    input logic [EW-1:0] dst_idx_o,
    input logic [SW-1:0] dst_sub_o,
    input logic          valid_o,
    input logic          grp_end_o,
    input logic          done_o
);

    // R5
    valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o));

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && !$past(start_i)) |-> $past(valid_o && grp_end_o));

    // R6
    vl_zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (vl_i == '0)) |=> (done_o && !valid_o));

    // R7
    no_issue_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i && !step_i) |=> !valid_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> ($stable(src_idx_o) && $stable(src_sub_o) &&
                                    $stable(dst_idx_o) && $stable(dst_sub_o)));

endmodule

bind vec_step_seq vss_chk #(.EW(STEP_W), .SW(SUB_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .step_i    (step_i),
    .vl_i      (vl_i),
    .src_idx_o (src_idx_o),
    .src_sub_o (src_sub_o),
    .dst_idx_o (dst_idx_o),
    .dst_sub_o (dst_sub_o),
    .valid_o   (valid_o),
    .grp_end_o (grp_end_o),
    .done_o    (done_o)
);

// File: tb/vec_step_seq_tb_top.sv
`timescale 1ns/1ps
module vec_step_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, step_i, pack_i, unpack_i, vfirst_i;
    logic [6:0] vl_i, hphint_i;
    logic [1:0] subvl_i;
    logic [6:0] src_idx_o, dst_idx_o;
    logic [1:0] src_sub_o, dst_sub_o;
    logic       valid_o, grp_end_o, done_o;

    always #10 clk = ~clk;

    vec_step_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
        .vl_i(vl_i), .subvl_i(subvl_i), .pack_i(pack_i), .unpack_i(unpack_i),
        .vfirst_i(vfirst_i), .hphint_i(hphint_i),
        .src_idx_o(src_idx_o), .src_sub_o(src_sub_o),
        .dst_idx_o(dst_idx_o), .dst_sub_o(dst_sub_o),
        .valid_o(valid_o), .grp_end_o(grp_end_o), .done_o(done_o)
    );

    int    tests = 0;
    int    fails = 0;
    string cur_tag = "R1";
    bit    cmp_en = 1'b0;

    // Reference model state: 0 idle, 1 issuing, 2 paused, 3 done.
    int q_se[$], q_ss[$], q_de[$], q_ds[$];
    int m_state = 0, m_pos = 0, m_n = 0, m_hint = 0;
    bit m_vf = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic void build(input int vl, input int sub, input bit pk, input bit upk);
        q_se.delete(); q_ss.delete(); q_de.delete(); q_ds.delete();
        if (pk) begin
            for (int s = 0; s < sub; s++) for (int e = 0; e < vl; e++) begin q_se.push_back(e); q_ss.push_back(s); end
        end else begin
            for (int e = 0; e < vl; e++) for (int s = 0; s < sub; s++) begin q_se.push_back(e); q_ss.push_back(s); end
        end
        if (upk) begin
            for (int s = 0; s < sub; s++) for (int e = 0; e < vl; e++) begin q_de.push_back(e); q_ds.push_back(s); end
        end else begin
            for (int e = 0; e < vl; e++) for (int s = 0; s < sub; s++) begin q_de.push_back(e); q_ds.push_back(s); end
        end
    endfunction

    // Expected group-end flag for tuple p (R10).
    function automatic bit gexp(input int p);
        if (p == m_n - 1) return 1'b1;
        if (m_hint == 0) return 1'b0;
        return (q_se[p+1] / m_hint) != (q_se[p] / m_hint);
    endfunction

    // Reference model update on every clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pos = 0; m_n = 0;
        end else if (start_i) begin
            build(int'(vl_i), int'(subvl_i) + 1, pack_i, unpack_i);
            m_n = q_se.size(); m_hint = int'(hphint_i); m_vf = vfirst_i; m_pos = 0;
            m_state = (vl_i == 0) ? 3 : (vfirst_i ? 2 : 1);
        end else if (m_state == 1) begin
            if (m_pos == m_n - 1) m_state = 3;
            else begin
                bit g;
                g = gexp(m_pos);
                m_pos++;
                if (m_vf && (m_hint == 0 || g)) m_state = 2;
            end
        end else if (m_state == 2) begin
            if (step_i) m_state = 1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk(valid_o == (m_state == 1), m_vf ? "R7" : cur_tag, "valid", valid_o, m_state == 1);
            chk(done_o == (m_state == 3), "R5", "done", done_o, m_state == 3);
            if (m_state == 0) begin
                chk(src_idx_o == 0 && dst_idx_o == 0 && src_sub_o == 0 && dst_sub_o == 0,
                    "R1", "idle indices", src_idx_o, 0);
            end else if (m_n > 0) begin
                chk(int'(src_idx_o) == q_se[m_pos], cur_tag, "src_idx", src_idx_o, q_se[m_pos]);
                chk(int'(src_sub_o) == q_ss[m_pos], cur_tag, "src_sub", src_sub_o, q_ss[m_pos]);
                chk(int'(dst_idx_o) == q_de[m_pos], cur_tag, "dst_idx", dst_idx_o, q_de[m_pos]);
                chk(int'(dst_sub_o) == q_ds[m_pos], cur_tag, "dst_sub", dst_sub_o, q_ds[m_pos]);
                if (m_state == 1)
                    chk(grp_end_o == gexp(m_pos), "R10", "grp_end", grp_end_o, gexp(m_pos));
            end
        end
    end

    // Start a sequence, then scramble the config inputs (R12: ignored).
    task automatic start_cfg(input int vl, input int sv, input bit pk, input bit upk,
                             input bit vf, input int hint, input string tag);
        @(negedge clk);
        vl_i = 7'(vl); subvl_i = 2'(sv); pack_i = pk; unpack_i = upk;
        vfirst_i = vf; hphint_i = 7'(hint); start_i = 1'b1; cur_tag = tag;
        @(negedge clk);
        start_i = 1'b0;
        vl_i = 7'h5a; subvl_i = ~subvl_i; pack_i = ~pk; unpack_i = ~upk;
        vfirst_i = ~vf; hphint_i = 7'd1;
    endtask

    // Run to done; step pulses only while paused in vertical-first mode,
    // otherwise toggled freely to show they are ignored (R7).
    task automatic wait_done(input bit vf);
        int k = 0;
        while (m_state != 3 && k < 5000) begin
            @(negedge clk);
            k++;
            if (vf) step_i = (m_state == 2 && (k % 3 == 0)) || (m_state == 1 && k[0]);
            else    step_i = k[0];
        end
        chk(m_state == 3, cur_tag, "sequence completes", m_state, 3);
        step_i = 1'b1;
        repeat (3) @(negedge clk);
        step_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; step_i = 1'b0; vl_i = '0; subvl_i = '0;
        pack_i = 1'b0; unpack_i = 1'b0; vfirst_i = 1'b0; hphint_i = '0;
        repeat (3) begin
            @(negedge clk);
            chk(!valid_o && !done_o && src_idx_o == 0 && dst_idx_o == 0 &&
                src_sub_o == 0 && dst_sub_o == 0, "R1", "reset outputs", valid_o, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);

        start_cfg(5, 2, 0, 0, 0, 2, "R2");   wait_done(0);
        start_cfg(4, 1, 1, 0, 0, 3, "R3");   wait_done(0);
        start_cfg(3, 3, 0, 1, 0, 0, "R4");   wait_done(0);
        start_cfg(6, 1, 1, 1, 0, 4, "R3");   wait_done(0);
        start_cfg(0, 2, 0, 0, 0, 0, "R6");   wait_done(0);
        start_cfg(7, 1, 0, 0, 1, 3, "R8");   wait_done(1);
        start_cfg(4, 1, 1, 0, 1, 10, "R8");  wait_done(1);
        start_cfg(5, 2, 1, 1, 1, 2, "R8");   wait_done(1);
        start_cfg(3, 1, 1, 0, 1, 0, "R9");   wait_done(1);
        start_cfg(1, 0, 0, 0, 0, 1, "R2");   wait_done(0);
        start_cfg(10, 3, 0, 1, 0, 3, "R12");
        repeat (5) @(negedge clk);
        start_cfg(2, 1, 1, 0, 0, 1, "R11");  wait_done(0);
        start_cfg(127, 3, 0, 0, 0, 7, "R2"); wait_done(0);
        start_cfg(9, 2, 0, 1, 1, 4, "R12");  wait_done(1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule